// File: doc/BRIEF.md
# Mirrored Single-Port Memory with Copy Compare

This block is a small synchronous single-port memory that keeps two copies of its contents. Each write goes to a primary array and to a backup array in the same cycle. Both arrays are read at the same address through registered read ports, and both words are brought out side by side. A flag reports when the two copies disagree, so any corruption of stored data in either copy becomes visible.

The mismatch flag is registered and lines up with the two read words. It only reports on locations that have been written since the last reset, because contents that were never written are undefined. A fault port lets a test flip chosen bits of the backup copy in place, which exercises the compare path without touching the primary copy. Array contents have no reset and no preload.

Top module: `mram_mirror`

## Requirements
- R1: Each copy holds 16 words of 4 bits, selected by the 4-bit `addr`. When `we` is 1 at a rising edge, `wdata` is stored at `addr` in both copies.
- R2: The read path is registered. After a rising edge, `rdata_pri` and `rdata_bak` show the words that were stored at the `addr` presented before that edge.
- R3: When `addr` is written in a cycle, the read of that cycle returns the contents from before the write, on both outputs.
- R4: With no fault injected, a location read after being written gives identical `rdata_pri` and `rdata_bak`, both equal to the last written data.
- R5: `mismatch` is valid in the same cycle as the read words. It is 1 exactly when the location that was read has been written since reset and its two copies differ.
- R6: `mismatch` stays 0 on a read of a location that has not been written since reset, even if its two copies differ.
- R7: A synchronous active-low `rst_n` sets both read outputs to 0, sets `mismatch` to 0 and forgets which locations were written. It does not change any stored word.
- R8: When `we` is 0 and `fault_mask` is nonzero at a rising edge, the backup word at `addr` is XORed with `fault_mask`. The primary word is left unchanged. `fault_mask` is ignored when `we` is 1.
- R9: After a fault on a written location, the next read of that address reports `mismatch` = 1 and the flipped backup word. Rewriting the location clears the disagreement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the read registers, flag and written record |
| we | input | 1 | Write enable for both copies |
| addr | input | 4 | Word address for read and write |
| wdata | input | 4 | Write data |
| fault_mask | input | 4 | Bits to flip in the backup word at `addr` when not writing |
| rdata_pri | output | 4 | Registered read word from the primary copy |
| rdata_bak | output | 4 | Registered read word from the backup copy |
| mismatch | output | 1 | Registered flag: the written location just read differs between copies |

## Verification
Some rules are checked by assertions on every cycle: a raised flag always comes with differing read words, a write followed by a read returns the written word, a repeated write to one address returns the older data, a write marks its location as written, and the written record is empty after reset. Other behaviour can only be shown by bench scenarios. These include the flag staying low on faulted locations that were never written, reset leaving stored words intact, the fault port being ignored during writes, and a rewrite clearing a flipped word. Randomized traffic checked against a bench model covers the interaction of reads, writes and sparse faults.

// File: rtl/mram_pkg.sv
// Package: shared constants for the mirrored memory.
// Assumes exactly two copies, primary at index 0 and backup at index 1.
package mram_pkg;
    localparam int ADDR_W_DEF = 4;
    localparam int DATA_W_DEF = 4;
    localparam int NUM_COPIES = 2;
    localparam int COPY_PRI   = 0;
    localparam int COPY_BAK   = 1;
endpackage

// File: rtl/mram_copy.sv
// One storage copy: 2**ADDR_W words, written synchronously, with a registered read.
// It also shows the addressed word combinationally so that the compare sees the
// pre-write contents. flip_mask XORs the addressed word when no write occurs.
// Assumes the contents have no reset; only the read register is reset.
module mram_copy #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] flip_mask,
    output logic [DATA_W-1:0] cur_word,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Addressed word before this cycle's update.
    assign cur_word = store[addr];

    // Array update: a write has priority over a fault flip.
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end else if (flip_mask != '0) begin
            store[addr] <= store[addr] ^ flip_mask;
        end
    end

    // Registered read port, read-before-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
        end else begin
            rd_word <= cur_word;
        end
    end

    // R2
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && !we && flip_mask == '0 && addr == $past(addr))
        |=> rd_word == $past(wdata, 2));

    // R3
    rd_old_on_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $past(we) && addr == $past(addr))
        |=> rd_word == $past(wdata, 2));
endmodule

// File: rtl/mram_seen.sv
// Written-since-reset record: one bit per location, set by a write and cleared
// by the synchronous reset. It reports the bit for the current address before
// this cycle's write is recorded.
module mram_seen #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] seen_q;

    // Look up the old record for the addressed location.
    assign hit = seen_q[addr];

    // Mark locations on write; forget all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (we) begin
            seen_q[addr] <= 1'b1;
        end
    end

    // R5
    wr_marks_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> seen_q[$past(addr)]);

    // R7
    rst_clears_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> seen_q == '0);
endmodule

// File: rtl/mram_mirror.sv
// Mirrored single-port memory. Each write lands in both copies. Both registered
// read words come out together with a registered disagreement flag, which is
// qualified by the written-since-reset record. fault_mask corrupts only the
// backup copy and is meant as a test hook.
module mram_mirror
    import mram_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] fault_mask,
    output logic [DATA_W-1:0] rdata_pri,
    output logic [DATA_W-1:0] rdata_bak,
    output logic              mismatch
);
    logic [DATA_W-1:0] cur_w [NUM_COPIES];
    logic [DATA_W-1:0] rd_w  [NUM_COPIES];
    logic              seen_hit;
    logic              mis_q;

    // One storage copy per index; only the backup copy takes the fault mask.
    for (genvar g = 0; g < NUM_COPIES; g++) begin : g_copy
        mram_copy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) copy_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (we),
            .addr      (addr),
            .wdata     (wdata),
            .flip_mask ((g == COPY_BAK) ? fault_mask : {DATA_W{1'b0}}),
            .cur_word  (cur_w[g]),
            .rd_word   (rd_w[g])
        );
    end

    mram_seen #(.ADDR_W(ADDR_W)) seen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .addr  (addr),
        .hit   (seen_hit)
    );

    // Register the compare of the pre-write words, aligned with the read ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mis_q <= 1'b0;
        end else begin
            mis_q <= seen_hit && (cur_w[COPY_PRI] != cur_w[COPY_BAK]);
        end
    end

    assign rdata_pri = rd_w[COPY_PRI];
    assign rdata_bak = rd_w[COPY_BAK];
    assign mismatch  = mis_q;

    // R5
    flag_needs_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> (rdata_pri != rdata_bak));

    // R4
    copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && !we && fault_mask == '0 && addr == $past(addr))
        |=> (rdata_pri == rdata_bak) && !mismatch);
endmodule

// File: tb/mram_mirror_tb_top.sv
module mram_mirror_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] fault_mask = '0;
    logic [3:0] rdata_pri;
    logic [3:0] rdata_bak;
    logic       mismatch;

    int n_chk = 0;
    int n_fail = 0;

    logic [3:0] pri_m [16];
    logic [3:0] bak_m [16];
    logic       known_m [16];
    logic       seen_m [16];

    always #4 clk = ~clk;

    mram_mirror dut_i (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .fault_mask(fault_mask), .rdata_pri(rdata_pri), .rdata_bak(rdata_bak),
        .mismatch(mismatch)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_flag(input logic [3:0] a);
        return seen_m[a] && (pri_m[a] != bak_m[a]);
    endfunction

    // One cycle: drive at negedge, compute expectation, sample after the edge.
    task automatic step(input logic w, input logic [3:0] a, input logic [3:0] d,
                        input logic [3:0] m, input string dtag, input string ftag);
        logic       ok_d;
        logic [3:0] ep, eb;
        logic       ef;
        we = w; addr = a; wdata = d; fault_mask = m;
        ok_d = known_m[a]; ep = pri_m[a]; eb = bak_m[a]; ef = exp_flag(a);
        if (w) begin
            pri_m[a] = d; bak_m[a] = d; known_m[a] = 1'b1; seen_m[a] = 1'b1;
        end else if (m != 4'd0) begin
            bak_m[a] = bak_m[a] ^ m;
        end
        @(posedge clk); #1;
        if (ok_d) begin
            check(rdata_pri == ep, {dtag, " rdata_pri"}, int'(rdata_pri), int'(ep));
            check(rdata_bak == eb, {dtag, " rdata_bak"}, int'(rdata_bak), int'(eb));
        end
        check(mismatch == ef, {ftag, " mismatch"}, int'(mismatch), int'(ef));
        @(negedge clk);
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0; we = 1'b0; fault_mask = '0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            check(rdata_pri == 4'd0, "R7 reset rdata_pri", int'(rdata_pri), 0);
            check(rdata_bak == 4'd0, "R7 reset rdata_bak", int'(rdata_bak), 0);
            check(mismatch == 1'b0, "R7 reset mismatch", int'(mismatch), 0);
            @(negedge clk);
        end
        for (int i = 0; i < 16; i++) seen_m[i] = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) begin
            pri_m[i] = '0; bak_m[i] = '0; known_m[i] = 1'b0; seen_m[i] = 1'b0;
        end
        @(negedge clk);
        do_reset(3);

        // R6: flip an unwritten location, then read it: flag must stay low.
        step(1'b0, 4'd5, 4'd0, 4'b0010, "R6", "R6");
        step(1'b0, 4'd5, 4'd0, 4'd0, "R6", "R6");

        // R1 / R4: fill every word, then read all back.
        for (int i = 0; i < 16; i++) step(1'b1, 4'(i), 4'(i) ^ 4'hA, 4'd0, "R1", "R1");
        for (int i = 0; i < 16; i++) step(1'b0, 4'(i), 4'd0, 4'd0, "R4", "R4");

        // R2: back-to-back reads at alternating addresses.
        step(1'b0, 4'd2, 4'd0, 4'd0, "R2", "R2");
        step(1'b0, 4'd13, 4'd0, 4'd0, "R2", "R2");

        // R3: rewrite the same address on consecutive cycles.
        step(1'b1, 4'd3, 4'd7, 4'd0, "R3", "R3");
        step(1'b1, 4'd3, 4'd9, 4'd0, "R3", "R3");
        step(1'b0, 4'd3, 4'd0, 4'd0, "R3", "R3");

        // R8 / R9: fault a written word, read it, read a neighbour, rewrite it.
        step(1'b0, 4'd6, 4'd0, 4'b1000, "R8", "R8");
        step(1'b0, 4'd6, 4'd0, 4'd0, "R8", "R9");
        step(1'b0, 4'd7, 4'd0, 4'd0, "R9", "R9");
        step(1'b1, 4'd8, 4'd5, 4'b0001, "R8", "R8");
        step(1'b0, 4'd8, 4'd0, 4'd0, "R8", "R8");
        step(1'b1, 4'd6, 4'd4, 4'd0, "R9", "R9");
        step(1'b0, 4'd6, 4'd0, 4'd0, "R9", "R9");

        // R7: fault, reset, read: contents kept, flag low.
        step(1'b0, 4'd9, 4'd0, 4'b0101, "R7", "R7");
        do_reset(2);
        step(1'b0, 4'd9, 4'd0, 4'd0, "R7", "R7");
        step(1'b0, 4'd1, 4'd0, 4'd0, "R7", "R7");

        // Random traffic with sparse faults.
        for (int i = 0; i < 600; i++) begin
            logic       w;
            logic [3:0] a, d, m;
            w = ($urandom % 2) == 0;
            a = 4'($urandom);
            d = 4'($urandom);
            m = (($urandom % 10) == 0) ? 4'(1 << ($urandom % 4)) : 4'd0;
            step(w, a, d, m, "R2", "R5");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule